// File: doc/BRIEF.md
# Circulant Sub-Block Rotator with Scaled Shift

This block applies one non-zero entry of a quasi-cyclic parity-check matrix to a single information sub-block. A base matrix stores one shift value per entry, defined for the largest expansion factor. For whatever expansion factor `z` is in use (24 to 96, that is, 576 to 2304 bit codewords of 24 sub-blocks), the block first rescales the stored value to a shift below `z`. It then rotates the low `z` bits of the incoming sub-block cyclically by that amount. An entry flagged as null stands for an all-zero sub-matrix, and its output is all zeros.

The shift is not looked up in a table for each code length. It is worked out on the fly from the base value, `z` and the code-rate select. Every rate uses proportional scaling except the rate-2/3 "A" code, which reduces the base value modulo `z`. The result is registered. Each accepted input produces its output exactly one cycle later, together with a valid flag. A full encoder puts several of these blocks side by side and feeds them from its own matrix storage.

Top module: `qc_circ_shift`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_data` is all zeros until the first accepted input.
- R2: `out_valid` in each cycle equals `in_valid` from the cycle before.
- R3: For every `rate_sel` value other than 2, the shift is s = floor(base × z / 96), reduced modulo z. The encodings are 0 = 1/2, 1 = 2/3 B, 3 = 3/4 A, 4 = 3/4 B, 5 = 5/6, and 6 and 7 behave like 0.
- R4: When `rate_sel` = 2 (rate 2/3 A), the shift is s = base mod z.
- R5: For an accepted non-null input, output bit i (for i < z) equals input bit (i + s) mod z one cycle later.
- R6: Output bits at positions z and above are 0. Input bits at positions z and above have no effect on the output.
- R7: An accepted input with `null_ent` = 1 gives an all-zero `out_data`, whatever the base and data values are.
- R8: When `in_valid` is 0, `out_data` keeps its previous value.
- R9: A base value of 96 or more is still reduced to a shift below z. For example, base 127 at z = 96 on a normal rate gives s = 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sub-block is valid this cycle |
| in_data | input | 96 | Information sub-block, low z bits used |
| z | input | 7 | Expansion factor (24..96) |
| rate_sel | input | 3 | Code-rate select, encoding as in R3/R4 |
| base | input | 7 | Base-matrix shift value |
| null_ent | input | 1 | Entry is an all-zero sub-matrix |
| out_valid | output | 1 | Output sub-block is valid |
| out_data | output | 96 | Rotated sub-block |

## Verification
A wrong shift value shows at the ports in the very next cycle. The rotated word moves to a different offset, so only a few bit positions change, and these can be missed unless the input data has distinct bit patterns. The bench therefore drives random 96-bit words and sweeps `z` across its range. A fault in the modulo or in the scaling arithmetic only appears for certain pairs of base value and `z`. The directed cases cover the rounding edge (base 95 at z = 24), the rate-A modulo path and out-of-range base values. A stuck valid or hold register shows up on the first idle cycle.

// File: rtl/qcs_pkg.sv
package qcs_pkg;
    typedef enum logic [2:0] {
        RATE_HALF = 3'd0,
        RATE_2_3B = 3'd1,
        RATE_2_3A = 3'd2,
        RATE_3_4A = 3'd3,
        RATE_3_4B = 3'd4,
        RATE_5_6  = 3'd5
    } rate_e;

    // True when the rate uses plain modulo reduction instead of scaling
    function automatic logic uses_modulo(input logic [2:0] sel);
        return sel == RATE_2_3A;
    endfunction
endpackage

// File: rtl/qcs_shift_scale.sv
module qcs_shift_scale #(
    parameter int ZMAX = 96,
    parameter int ZMIN = 24,
    parameter int ZW   = 7,
    parameter int BW   = 7
) (
    input  logic [BW-1:0] base,
    input  logic [ZW-1:0] z,
    input  logic          mod_mode,
    output logic [ZW-1:0] shift
);
    localparam int PW    = BW + ZW;
    localparam int STEPS = ((1 << BW) + ZMIN - 1) / ZMIN;

    logic [PW-1:0] prod;
    logic [PW-1:0] raw;

    always_comb begin
        prod = PW'(base) * PW'(z);
        raw  = mod_mode ? PW'(base) : prod / PW'(ZMAX);
        // bounded conditional subtraction: enough steps for any base and z >= ZMIN
        for (int k = 0; k < STEPS; k++) begin
            if (raw >= PW'(z)) begin
                raw = raw - PW'(z);
            end
        end
        shift = raw[ZW-1:0];
    end
endmodule

// File: rtl/qcs_rotate.sv
module qcs_rotate #(
    parameter int ZMAX = 96,
    parameter int ZW   = 7
) (
    input  logic [ZMAX-1:0] din,
    input  logic [ZW-1:0]   z,
    input  logic [ZW-1:0]   shift,
    output logic [ZMAX-1:0] dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < ZMAX; i++) begin
            int idx;
            idx = i + int'(shift);
            if (idx >= int'(z)) begin
                idx = idx - int'(z);
            end
            if (i < int'(z) && idx < ZMAX) begin
                dout[i] = din[idx];
            end
        end
    end
endmodule

// File: rtl/qc_circ_shift.sv
module qc_circ_shift #(
    parameter int ZMAX = 96,
    parameter int ZMIN = 24,
    parameter int ZW   = 7,
    parameter int BW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [ZMAX-1:0] in_data,
    input  logic [ZW-1:0]   z,
    input  logic [2:0]      rate_sel,
    input  logic [BW-1:0]   base,
    input  logic            null_ent,
    output logic            out_valid,
    output logic [ZMAX-1:0] out_data
);
    import qcs_pkg::*;

    typedef struct packed {
        logic            vld;
        logic [ZMAX-1:0] data;
    } stage_t;

    stage_t          st_d, st_q;
    logic [ZW-1:0]   shift_amt;
    logic [ZMAX-1:0] rotated;

    qcs_shift_scale #(.ZMAX(ZMAX), .ZMIN(ZMIN), .ZW(ZW), .BW(BW)) u_scale (
        .base     (base),
        .z        (z),
        .mod_mode (uses_modulo(rate_sel)),
        .shift    (shift_amt)
    );

    qcs_rotate #(.ZMAX(ZMAX), .ZW(ZW)) u_rot (
        .din   (in_data),
        .z     (z),
        .shift (shift_amt),
        .dout  (rotated)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.data = null_ent ? '0 : rotated;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.data;
endmodule

module qc_circ_shift_chk #(
    parameter int ZMAX = 96,
    parameter int ZW   = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [ZMAX-1:0] in_data,
    input logic [ZW-1:0]   z,
    input logic            null_ent,
    input logic            out_valid,
    input logic [ZMAX-1:0] out_data
);
    logic [ZMAX-1:0] zmask;
    assign zmask = (ZMAX'(1) << z) - ZMAX'(1);

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R6
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_data & ~$past(zmask)) == '0);
    // R7
    null_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && null_ent) |=> out_data == '0);
    // R8
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // R5
    weight_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !null_ent) |=> $countones(out_data) == $past($countones(in_data & zmask)));
endmodule

bind qc_circ_shift qc_circ_shift_chk #(.ZMAX(ZMAX), .ZW(ZW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .z         (z),
    .null_ent  (null_ent),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/qc_circ_shift_test.sv
module qc_circ_shift_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [95:0] in_data = '0;
    logic [6:0]  z = 7'd96;
    logic [2:0]  rate_sel = '0;
    logic [6:0]  base = '0;
    logic        null_ent = 1'b0;
    logic        out_valid;
    logic [95:0] out_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    bit    m_vld = 0;
    logic [95:0] m_data = '0;
    string m_tag = "R1";

    always #10 clk = ~clk;

    qc_circ_shift uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .z(z), .rate_sel(rate_sel), .base(base), .null_ent(null_ent),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [95:0] ref_out(input logic [95:0] d, input int zz,
                                            input int rs, input int b, input bit nul);
        logic [95:0] r = '0;
        int s;
        if (nul) return '0;
        if (rs == 2) s = b % zz;
        else         s = ((b * zz) / 96) % zz;
        for (int i = 0; i < zz; i++) r[i] = d[(i + s) % zz];
        return r;
    endfunction

    task automatic compare();
        checks++;
        if (out_valid !== m_vld) begin
            errors++;
            $display("FAIL %s/R2 valid: got %0b expected %0b", m_tag, out_valid, m_vld);
        end
        checks++;
        if (out_data !== m_data) begin
            errors++;
            $display("FAIL %s data: got %h expected %h", m_tag, out_data, m_data);
        end
    endtask

    // compare previous cycle's result, then drive new inputs and advance the model
    task automatic step(input bit v, input logic [95:0] d, input int zz, input int rs,
                        input int b, input bit nul, input string tag);
        @(negedge clk);
        compare();
        in_valid = v; in_data = d; z = 7'(zz); rate_sel = 3'(rs);
        base = 7'(b); null_ent = nul;
        m_vld = v;
        if (v) m_data = ref_out(d, zz, rs, b, nul);
        m_tag = tag;
    endtask

    function automatic logic [95:0] rnd96();
        return {$urandom, $urandom, $urandom};
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [95:0] pat;
        repeat (3) @(negedge clk);
        compare();                                  // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        step(0, rnd96(), 96, 0, 0, 0, "R1");        // R1 after release, idle
        pat = rnd96();
        step(1, pat, 96, 0, 0, 0, "R5");            // identity shift
        step(1, pat, 24, 0, 95, 0, "R3");           // floor(95*24/96)=23
        step(1, pat, 60, 5, 40, 0, "R3");           // floor(40*60/96)=25
        step(1, pat, 24, 2, 50, 0, "R4");           // 50 mod 24 = 2
        step(1, pat, 96, 2, 95, 0, "R4");           // 95 mod 96 = 95
        step(1, pat, 96, 3, 127, 0, "R9");          // 127 -> 31
        step(1, pat, 24, 2, 127, 0, "R9");          // 127 mod 24 = 7
        step(1, '1, 40, 0, 10, 0, "R6");            // upper bits set, must vanish
        step(1, pat, 48, 1, 33, 1, "R7");           // null entry
        step(0, rnd96(), 72, 2, 5, 0, "R8");        // idle: hold
        step(0, rnd96(), 24, 0, 1, 1, "R8");
        step(1, 96'h1, 32, 7, 64, 0, "R3");         // reserved sel scales
        for (int n = 0; n < 400; n++) begin
            int zz = 24 + 4 * ($urandom % 19);
            step($urandom % 4 != 0, rnd96(), zz, $urandom % 8, $urandom % 128,
                 $urandom % 8 == 0, "R5");
        end
        step(0, '0, 96, 0, 0, 0, "R8");
        @(negedge clk);
        compare();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule